// File: doc/BRIEF.md
# Framed Synchronous Serial Transmitter

This block serialises parallel data words into frames on a bit-rate clock, one bit per clock cycle. A frame begins on a start event whose source is chosen by configuration: free-running, an edge of a trigger input, or the trigger level. Each frame may open with a synchronisation field taken from a dedicated sync-pattern input, during which a frame-sync strobe is raised. An idle gap of programmable length follows. The payload comes next: a programmable number of words of programmable width, sent most- or least-significant bit first.

Words come in over a ready/valid handshake, one word per slot. If no word is offered when a slot opens, the slot carries the idle level and an underrun pulse is raised. The data line rests at a configurable idle level whenever nothing is being sent. A minimum frame period pads short frames so that free-running frames repeat at a fixed rate. Configuration must be held stable while a frame is in flight.

Top module: `framed_serial_tx`

## Requirements
- R1: When no frame is active, txData equals cfgIdleLevel, and txSync, underrun and dataReady are low. This also holds right after reset.
- R2: cfgStartMode selects the start event: 0 starts whenever the block is free, 1 a rising edge of startTrig, 2 a falling edge, and 3 startTrig being high. Events seen while a frame runs are ignored. Frame cycle 0 is the cycle after the clock edge that sees the event.
- R3: With cfgSyncEn set, frame cycles 0 to cfgSyncLen carry bits of cfgSyncData. MSB-first sends bit cfgSyncLen down to bit 0, and LSB-first sends bit 0 upward. txSync is high in exactly those cycles. With cfgSyncEn clear there is no sync field and txSync stays low.
- R4: After the sync field, cfgStartDly cycles (0 to 255) carry the idle level.
- R5: Then cfgWordCount+1 words of cfgWordLen+1 bits each are sent back to back. With cfgMsbFirst=1 a word goes out from bit cfgWordLen down to bit 0, and with cfgMsbFirst=0 from bit 0 upward.
- R6: dataReady is high in exactly the cycle before each word slot's first bit. The word is taken at that clock edge when dataValid is high. dataValid and dataIn at any other time have no effect on the output.
- R7: If dataValid is low at a slot's taking edge, the whole slot carries the idle level and underrun is high in the slot's first cycle only.
- R8: A frame lasts max(content length, cfgFramePeriod+1) cycles, with the padding at the idle level. A frame that starts at the end of another begins in the next cycle, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgStartMode | input | 2 | Start event selection |
| startTrig | input | 1 | External start trigger |
| cfgSyncEn | input | 1 | Enable sync field |
| cfgSyncLen | input | 5 | Sync field length minus one |
| cfgSyncData | input | 32 | Sync pattern |
| cfgStartDly | input | 8 | Idle cycles between sync field and payload |
| cfgWordLen | input | 5 | Word length minus one |
| cfgWordCount | input | 4 | Words per frame minus one |
| cfgMsbFirst | input | 1 | 1 = most significant bit first |
| cfgIdleLevel | input | 1 | Line level outside data |
| cfgFramePeriod | input | 9 | Minimum frame length minus one |
| dataIn | input | 32 | Word to send |
| dataValid | input | 1 | dataIn holds a word |
| dataReady | output | 1 | Word taken at the next edge if valid |
| txData | output | 1 | Serial data line |
| txSync | output | 1 | High during sync field |
| underrun | output | 1 | Slot started without a word |

## Verification
The bench builds the block with its defaults: 32-bit words and sync pattern, up to 16 words per frame, an 8-bit start delay and a 9-bit frame period. Full-width words with every index, the 255-cycle delay and frames up to 512 cycles are therefore reached. Random frames vary all fields, the bit order and word availability. Directed frames cover the one-bit frame, the all-underrun frame, padding by the period, and back-to-back free-running frames with and without padding. They also run the falling-edge and level start modes.

// File: rtl/fstx_pkg.sv
package fstx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DELAY,
    ST_DATA,
    ST_GAP
  } fstxState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic captureSync;  // frame starts at this edge
    logic slotStart;    // a word slot starts at this edge
    logic sendSync;     // current cycle is a sync bit
    logic sendData;     // current cycle is a payload bit
  } fstxStrobes_t;

endpackage

// File: rtl/fstx_ctrl.sv
module fstx_ctrl
  import fstx_pkg::*;
#(
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned COUNT_W  = 4,
  parameter int unsigned DLY_W    = 8,
  parameter int unsigned PERIOD_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          cfgStartMode,
  input  logic                startTrig,
  input  logic                cfgSyncEn,
  input  logic [IDX_W-1:0]    cfgSyncLen,
  input  logic [DLY_W-1:0]    cfgStartDly,
  input  logic [IDX_W-1:0]    cfgWordLen,
  input  logic [COUNT_W-1:0]  cfgWordCount,
  input  logic [PERIOD_W-1:0] cfgFramePeriod,
  output fstxStrobes_t        strb,
  output logic [IDX_W-1:0]    bitCnt
);

  localparam int unsigned CNT_W  = (DLY_W > IDX_W) ? DLY_W : IDX_W;
  localparam int unsigned PCNT_W = PERIOD_W + 1;

  fstxState_t          state, nxt;
  logic [CNT_W-1:0]    cnt;
  logic [COUNT_W-1:0]  wordCnt;
  logic [PCNT_W-1:0]   periodCnt;
  logic                trigQ;

  logic startEvt, startNow, frameDone;
  logic lastSync, lastDly, lastData, lastWord, periodReached;
  fstxState_t afterSync, firstState;

  always_comb begin
    unique case (cfgStartMode)
      2'd0:    startEvt = 1'b1;
      2'd1:    startEvt = startTrig & ~trigQ;
      2'd2:    startEvt = ~startTrig & trigQ;
      default: startEvt = startTrig;
    endcase
  end

  assign lastSync      = (state == ST_SYNC)  && (cnt == CNT_W'(cfgSyncLen));
  assign lastDly       = (state == ST_DELAY) && ((cnt + CNT_W'(1)) == CNT_W'(cfgStartDly));
  assign lastData      = (state == ST_DATA)  && (cnt == CNT_W'(cfgWordLen));
  assign lastWord      = (wordCnt == cfgWordCount);
  assign periodReached = (periodCnt >= PCNT_W'(cfgFramePeriod));
  assign frameDone     = ((lastData && lastWord) || (state == ST_GAP)) && periodReached;
  assign startNow      = ((state == ST_IDLE) || frameDone) && startEvt;

  assign afterSync  = (cfgStartDly != '0) ? ST_DELAY : ST_DATA;
  assign firstState = cfgSyncEn ? ST_SYNC : afterSync;

  always_comb begin
    nxt = state;
    if (startNow) begin
      nxt = firstState;
    end else begin
      unique case (state)
        ST_IDLE:  nxt = ST_IDLE;
        ST_SYNC:  if (lastSync) nxt = afterSync;
        ST_DELAY: if (lastDly) nxt = ST_DATA;
        ST_DATA:  if (lastData && lastWord) nxt = periodReached ? ST_IDLE : ST_GAP;
        ST_GAP:   if (periodReached) nxt = ST_IDLE;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      wordCnt   <= '0;
      periodCnt <= '0;
      trigQ     <= 1'b0;
    end else begin
      trigQ <= startTrig;
      state <= nxt;
      if ((nxt != state) || lastData) cnt <= '0;
      else                            cnt <= cnt + CNT_W'(1);
      if (startNow)                   wordCnt <= '0;
      else if (lastData && !lastWord) wordCnt <= wordCnt + COUNT_W'(1);
      if (startNow)                                    periodCnt <= '0;
      else if (state != ST_IDLE && periodCnt != '1)    periodCnt <= periodCnt + PCNT_W'(1);
    end
  end

  always_comb begin
    strb.captureSync = startNow;
    strb.slotStart   = (nxt == ST_DATA) && ((state != ST_DATA) || lastData);
    strb.sendSync    = (state == ST_SYNC);
    strb.sendData    = (state == ST_DATA);
  end

  assign bitCnt = cnt[IDX_W-1:0];

  AST_READY_LEADS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    strb.slotStart |=> (state == ST_DATA) && (cnt == '0)); // R6
  AST_SYNC_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.sendSync) |-> $past(cnt) == CNT_W'(cfgSyncLen)); // R3
  AST_DELAY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DELAY) |-> cnt < CNT_W'(cfgStartDly)); // R4
  AST_WORD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> wordCnt <= cfgWordCount); // R5
  AST_GAP_IN_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |-> periodCnt <= PCNT_W'(cfgFramePeriod)); // R8

endmodule

// File: rtl/fstx_datapath.sv
module fstx_datapath
  import fstx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  fstxStrobes_t      strb,
  input  logic [IDX_W-1:0]  bitCnt,
  input  logic [DATA_W-1:0] cfgSyncData,
  input  logic [IDX_W-1:0]  cfgSyncLen,
  input  logic [IDX_W-1:0]  cfgWordLen,
  input  logic              cfgMsbFirst,
  input  logic              cfgIdleLevel,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              dataValid,
  output logic              txData,
  output logic              txSync,
  output logic              underrun
);

  logic [DATA_W-1:0] syncReg, wordReg;
  logic              wordOk;
  logic [IDX_W-1:0]  syncIdx, wordIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncReg  <= '0;
      wordReg  <= '0;
      wordOk   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (strb.captureSync) syncReg <= cfgSyncData;
      if (strb.slotStart) begin
        wordOk <= dataValid;
        if (dataValid) wordReg <= dataIn;
      end
      underrun <= strb.slotStart & ~dataValid;
    end
  end

  assign syncIdx = cfgMsbFirst ? (cfgSyncLen - bitCnt) : bitCnt;
  assign wordIdx = cfgMsbFirst ? (cfgWordLen - bitCnt) : bitCnt;

  always_comb begin
    if (strb.sendSync)                 txData = syncReg[syncIdx];
    else if (strb.sendData && wordOk)  txData = wordReg[wordIdx];
    else                               txData = cfgIdleLevel;
  end

  assign txSync = strb.sendSync;

  AST_UNDERRUN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> txData == cfgIdleLevel); // R7
  AST_UNDERRUN_FIRST_BIT: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> strb.sendData && (bitCnt == '0)); // R7

endmodule

// File: rtl/framed_serial_tx.sv
module framed_serial_tx
  import fstx_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned COUNT_W  = 4,
  parameter int unsigned DLY_W    = 8,
  parameter int unsigned PERIOD_W = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 cfgStartMode,
  input  logic                       startTrig,
  input  logic                       cfgSyncEn,
  input  logic [$clog2(DATA_W)-1:0]  cfgSyncLen,
  input  logic [DATA_W-1:0]          cfgSyncData,
  input  logic [DLY_W-1:0]           cfgStartDly,
  input  logic [$clog2(DATA_W)-1:0]  cfgWordLen,
  input  logic [COUNT_W-1:0]         cfgWordCount,
  input  logic                       cfgMsbFirst,
  input  logic                       cfgIdleLevel,
  input  logic [PERIOD_W-1:0]        cfgFramePeriod,
  input  logic [DATA_W-1:0]          dataIn,
  input  logic                       dataValid,
  output logic                       dataReady,
  output logic                       txData,
  output logic                       txSync,
  output logic                       underrun
);

  localparam int unsigned IDX_W = $clog2(DATA_W);

  fstxStrobes_t     strb;
  logic [IDX_W-1:0] bitCnt;

  fstx_ctrl #(
    .IDX_W(IDX_W), .COUNT_W(COUNT_W), .DLY_W(DLY_W), .PERIOD_W(PERIOD_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgStartMode(cfgStartMode), .startTrig(startTrig),
    .cfgSyncEn(cfgSyncEn), .cfgSyncLen(cfgSyncLen),
    .cfgStartDly(cfgStartDly), .cfgWordLen(cfgWordLen),
    .cfgWordCount(cfgWordCount), .cfgFramePeriod(cfgFramePeriod),
    .strb(strb), .bitCnt(bitCnt)
  );

  fstx_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .bitCnt(bitCnt),
    .cfgSyncData(cfgSyncData), .cfgSyncLen(cfgSyncLen),
    .cfgWordLen(cfgWordLen), .cfgMsbFirst(cfgMsbFirst),
    .cfgIdleLevel(cfgIdleLevel), .dataIn(dataIn), .dataValid(dataValid),
    .txData(txData), .txSync(txSync), .underrun(underrun)
  );

  assign dataReady = strb.slotStart;

  AST_SYNC_NOT_PAYLOAD: assert property (@(posedge clk) disable iff (!rstN)
    txSync |-> !dataReady || !$past(dataReady)); // R3

endmodule

// File: tb/framed_serial_tx_test.sv
module framed_serial_tx_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  cfgStartMode;
  logic        startTrig;
  logic        cfgSyncEn;
  logic [4:0]  cfgSyncLen;
  logic [31:0] cfgSyncData;
  logic [7:0]  cfgStartDly;
  logic [4:0]  cfgWordLen;
  logic [3:0]  cfgWordCount;
  logic        cfgMsbFirst;
  logic        cfgIdleLevel;
  logic [8:0]  cfgFramePeriod;
  logic [31:0] dataIn;
  logic        dataValid;
  logic        dataReady, txData, txSync, underrun;

  always #4 clk = ~clk;

  framed_serial_tx uut (
    .clk(clk), .rstN(rstN), .cfgStartMode(cfgStartMode), .startTrig(startTrig),
    .cfgSyncEn(cfgSyncEn), .cfgSyncLen(cfgSyncLen), .cfgSyncData(cfgSyncData),
    .cfgStartDly(cfgStartDly), .cfgWordLen(cfgWordLen), .cfgWordCount(cfgWordCount),
    .cfgMsbFirst(cfgMsbFirst), .cfgIdleLevel(cfgIdleLevel),
    .cfgFramePeriod(cfgFramePeriod), .dataIn(dataIn), .dataValid(dataValid),
    .dataReady(dataReady), .txData(txData), .txSync(txSync), .underrun(underrun)
  );

  int checks = 0;
  int fails = 0;
  logic [31:0] words [0:31];
  bit          avail [0:31];
  int availPct;
  int S, D, W, N, L, F;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void calcFrame();
    S = cfgSyncEn ? int'(cfgSyncLen) + 1 : 0;
    D = int'(cfgStartDly);
    W = int'(cfgWordLen) + 1;
    N = int'(cfgWordCount) + 1;
    L = S + D + N * W;
    F = (L > int'(cfgFramePeriod) + 1) ? L : int'(cfgFramePeriod) + 1;
  endfunction

  function automatic bit slotAt(int c, int nF);
    int p;
    if (c < 0 || c >= nF * F) return 1'b0;
    p = c % F;
    if (p < S + D || p >= L) return 1'b0;
    return ((p - S - D) % W) == 0;
  endfunction

  function automatic void expAt(int c, int nF, output logic d, output logic s,
                                output logic u, output logic r, output string tag);
    int p, q, w, b, idx, k;
    d = cfgIdleLevel; s = 1'b0; u = 1'b0;
    r = slotAt(c + 1, nF);
    tag = "R1";
    if (c < 0 || c >= nF * F) return;
    p = c % F;
    if (p < S) begin
      s = 1'b1; tag = "R3";
      idx = cfgMsbFirst ? int'(cfgSyncLen) - p : p;
      d = cfgSyncData[idx];
    end else if (p < S + D) begin
      tag = "R4";
    end else if (p < L) begin
      q = p - S - D; w = q / W; b = q % W;
      k = (c / F) * N + w;
      idx = cfgMsbFirst ? int'(cfgWordLen) - b : b;
      tag = avail[k] ? "R5" : "R7";
      d = avail[k] ? words[k][idx] : cfgIdleLevel;
      u = (b == 0) && !avail[k];
    end else begin
      tag = "R8";
    end
  endfunction

  task automatic drive(int c, int nF);
    int k;
    if (slotAt(c, nF)) begin
      k = (c / F) * N + ((c % F) - S - D) / W;
      dataIn = words[k];
      dataValid = avail[k];
    end else begin
      dataIn = $urandom;
      dataValid = 1'($urandom % 2);
    end
  endtask

  // mode 1 rising, 2 falling, 0 free-running, 3 level
  task automatic runFrames(int nF, int mode);
    logic eD, eS, eU, eR;
    string tag;
    int total;
    calcFrame();
    total = nF * F;
    for (int i = 0; i < 32; i++) begin
      words[i] = $urandom;
      avail[i] = (($urandom % 100) < availPct);
    end
    @(negedge clk);
    drive(0, nF);
    case (mode)
      0: cfgStartMode = 2'd0;
      1: startTrig = 1'b1;
      2: startTrig = 1'b0;
      default: begin cfgStartMode = 2'd3; startTrig = 1'b1; end
    endcase
    for (int c = 0; c < total + 4; c++) begin
      @(negedge clk);
      if (c == total - 1) begin
        if (mode == 0) cfgStartMode = 2'd1;
        if (mode == 3) startTrig = 1'b0;
      end
      #1;
      expAt(c, nF, eD, eS, eU, eR, tag);
      if (mode != 1 && c < total) tag = (c < F) ? "R2" : "R8";
      chk(txData === eD, tag, "txData", int'(txData), int'(eD));
      chk(txSync === eS, "R3", "txSync", int'(txSync), int'(eS));
      chk(underrun === eU, "R7", "underrun", int'(underrun), int'(eU));
      chk(dataReady === eR, "R6", "dataReady", int'(dataReady), int'(eR));
      if (mode == 1 && c == 0) startTrig = 1'b0;
      drive(c + 1, nF);
    end
    cfgStartMode = 2'd1;
  endtask

  task automatic setCfg(bit syncEn, int syncLen, int dly, int wlen, int wcnt,
                        bit msb, bit idle, int period);
    cfgSyncEn = syncEn; cfgSyncLen = 5'(syncLen); cfgStartDly = 8'(dly);
    cfgWordLen = 5'(wlen); cfgWordCount = 4'(wcnt); cfgMsbFirst = msb;
    cfgIdleLevel = idle; cfgFramePeriod = 9'(period); cfgSyncData = $urandom;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; cfgStartMode = 2'd1; startTrig = 1'b0; dataIn = '0; dataValid = 1'b0;
    availPct = 100;
    setCfg(1'b0, 0, 0, 7, 0, 1'b1, 1'b1, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(txData === 1'b1, "R1", "reset txData", int'(txData), 1);
    chk(txSync === 1'b0, "R1", "reset txSync", int'(txSync), 0);
    chk(underrun === 1'b0, "R1", "reset underrun", int'(underrun), 0);
    chk(dataReady === 1'b0, "R1", "reset dataReady", int'(dataReady), 0);

    // one-bit frame
    setCfg(1'b0, 0, 0, 0, 0, 1'b1, 1'b0, 0); runFrames(1, 1);
    // full sync, longest delay, MSB first
    setCfg(1'b1, 31, 255, 31, 1, 1'b1, 1'b1, 0); runFrames(1, 1);
    // LSB first with short sync
    setCfg(1'b1, 3, 2, 11, 3, 1'b0, 0, 0); runFrames(1, 1);
    // every slot starved
    availPct = 0;
    setCfg(1'b1, 4, 1, 7, 5, 1'b1, 1'b1, 0); runFrames(1, 1);
    availPct = 100;
    // period pads a short frame
    setCfg(1'b1, 2, 3, 3, 1, 1'b0, 1'b1, 300); runFrames(1, 1);
    // free-running, padded
    setCfg(1'b1, 5, 2, 7, 1, 1'b1, 1'b0, 40); runFrames(2, 0);
    // free-running without padding, payload restarts payload
    availPct = 70;
    setCfg(1'b0, 0, 0, 5, 2, 1'b0, 1'b1, 3); runFrames(2, 0);
    // falling edge: a rising edge must not start a frame
    setCfg(1'b1, 6, 1, 9, 1, 1'b1, 1'b0, 0);
    @(negedge clk); cfgStartMode = 2'd2; startTrig = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(txSync === 1'b0 && txData === 1'b0, "R2", "rise in falling mode",
          int'({txSync, txData}), 0);
      chk(dataReady === 1'b0, "R2", "rise in falling mode ready", int'(dataReady), 0);
    end
    runFrames(1, 2);
    // level mode
    setCfg(1'b1, 2, 0, 4, 0, 1'b0, 1'b1, 20); runFrames(2, 3);

    for (int t = 0; t < 30; t++) begin
      availPct = 60 + int'($urandom % 41);
      setCfg(1'($urandom % 2), int'($urandom % 32),
             (($urandom % 4) == 0) ? int'($urandom % 256) : int'($urandom % 6),
             int'($urandom % 32), int'($urandom % 16), 1'($urandom % 2),
             1'($urandom % 2),
             (($urandom % 3) == 0) ? int'($urandom % 512) : int'($urandom % 20));
      runFrames(1, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule